// File: doc/BRIEF.md
# Conditional Call/Return Unit

This block executes the two control-flow instructions of a small virtual machine: a conditional forward call and a conditional return. Each instruction is presented on the input ports for one cycle. The block decides whether the branch is taken, works out the next program counter and the result written to the destination register, and keeps its own stack of saved pairs. Each pair holds a 64-bit data value and a return address.

The branch condition compares operand B, as an unsigned 64-bit value, with the 32-bit immediate sign-extended to 64 bits. A taken call saves operand A together with the address of the following instruction, then jumps forward by a distance taken from the low seven bits of the 8-bit immediate. A taken return restores the most recent pair. It writes A XOR the saved value and jumps back to the saved address. An instruction that is not taken, a return on an empty stack and a call on a full stack all become a pass-through that writes C = A and moves on to the next instruction. All outputs are combinational from the presented instruction and the current stack. The stack changes on the rising clock edge that ends the instruction's cycle.

Top module: `callRetUnit`

## Requirements
- R1: The branch condition is true when opB, read as an unsigned 64-bit number, is less than or equal to imm32 sign-extended to 64 bits (for example imm32 = 32'hFFFFFFFF compares as 64'hFFFFFFFFFFFFFFFF).
- R2: A valid call or return whose branch is not taken sets resultWe = 1, resultC = opA and nextPc = pcIn + 16, and asserts neither stackPush nor stackPop.
- R3: A taken call asserts stackPush for one cycle, saves opA and pcIn + 16 as a new stack entry, and keeps resultWe = 0.
- R4: A taken call sets nextPc = pcIn + 16 * (imm8[6:0] + 1); imm8[7] has no effect.
- R5: A return presented while the stack is empty behaves as not taken (R2), whatever the condition.
- R6: A taken return asserts stackPop, sets resultWe = 1, resultC = opA XOR the saved value and nextPc = the saved return address, and removes that entry.
- R7: A call presented while the stack holds DEPTH entries behaves as not taken (R2) and leaves the stack unchanged.
- R8: Returns restore entries in last-in, first-out order across nested calls.
- R9: With instValid = 0, or with opClass other than 2'b01 (call) or 2'b10 (return), the block sets resultWe = 0 and nextPc = pcIn + 16, asserts neither stack strobe, and leaves the stack unchanged.
- R10: Reset (rstN = 0) empties the stack.
- R11: Program-counter arithmetic wraps modulo the program length of PROG_INSTR * 16 bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | An instruction is presented this cycle |
| opClass | input | 2 | 2'b01 call, 2'b10 return, other values not handled here |
| opA | input | 64 | Operand A |
| opB | input | 64 | Operand B, compared with the immediate |
| imm32 | input | 32 | 32-bit immediate, the comparison limit |
| imm8 | input | 8 | 8-bit immediate, bits 6:0 give the call distance |
| pcIn | input | PC_W (12) | Byte address of the current instruction |
| nextPc | output | PC_W (12) | Byte address of the next instruction |
| resultC | output | 64 | Result for the destination register |
| resultWe | output | 1 | Write enable for resultC |
| stackPush | output | 1 | A pair is saved on the stack at this edge |
| stackPop | output | 1 | A pair is removed from the stack at this edge |

## Verification
nextPc, resultC, resultWe and both stack strobes depend combinationally on the presented instruction, so each is due in the same cycle the instruction is driven. The stack update becomes visible only to an instruction presented after the next rising edge. The bench drives each instruction on a falling edge, samples every output 1 ns later, still before the rising edge, and then advances its own stack model at that edge. A later return then reads back any entry that a push or an ignored instruction could have changed.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_CALL = 2'b01,
    CLS_RET  = 2'b10,
    CLS_RSVD = 2'b11
  } opClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;       // save a pair
    logic pop;        // drop the top pair
    logic toCall;     // nextPc from call target
    logic toRet;      // nextPc from saved address
    logic mixStored;  // resultC = A ^ saved value
    logic writeC;     // result write enable
  } crStrobe_t;

  localparam int unsigned INSTR_BYTES = 16;
  localparam int unsigned DATA_W      = 64;

endpackage

// File: rtl/callRetCtrl.sv
module callRetCtrl
  import callret_pkg::*;
(
  input  logic       instValid,
  input  logic [1:0] opClass,
  input  logic       cmpLe,
  input  logic       stkEmpty,
  input  logic       stkFull,
  output crStrobe_t  strobe
);

  opClass_e cls;
  logic isCall;
  logic isRet;
  logic callGo;
  logic retGo;

  always_comb begin
    cls    = opClass_e'(opClass);
    isCall = instValid && (cls == CLS_CALL);
    isRet  = instValid && (cls == CLS_RET);
    // a full stack blocks a call, an empty one blocks a return
    callGo = isCall && cmpLe && !stkFull;
    retGo  = isRet && cmpLe && !stkEmpty;
  end

  always_comb begin
    strobe           = '0;
    strobe.push      = callGo;
    strobe.toCall    = callGo;
    strobe.pop       = retGo;
    strobe.toRet     = retGo;
    strobe.mixStored = retGo;
    // not-taken call and every return write C
    strobe.writeC    = (isCall && !callGo) || isRet;
  end

endmodule

// File: rtl/callRetDatapath.sv
module callRetDatapath
  import callret_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  crStrobe_t         strobe,
  input  logic [63:0]       opA,
  input  logic [63:0]       opB,
  input  logic [31:0]       imm32,
  input  logic [7:0]        imm8,
  input  logic [PC_W-1:0]   pcIn,
  output logic              cmpLe,
  output logic              stkEmpty,
  output logic              stkFull,
  output logic [PC_W-1:0]   nextPc,
  output logic [63:0]       resultC
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] valMem [DEPTH];
  logic [PC_W-1:0]   retMem [DEPTH];
  logic [CNT_W-1:0]  fillCnt;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  wrIdx;

  logic [63:0]       limitExt;
  logic [11:0]       ofsFull;
  logic [PC_W-1:0]   seqPc;
  logic [PC_W-1:0]   callTgt;

  // unsigned compare against the sign-extended immediate
  always_comb begin
    limitExt = {{32{imm32[31]}}, imm32};
    cmpLe    = (opB <= limitExt);
  end

  // PC arithmetic wraps at the width of pcIn
  always_comb begin
    ofsFull = {({1'b0, imm8[6:0]} + 8'd1), 4'b0000};
    seqPc   = pcIn + PC_W'(INSTR_BYTES);
    callTgt = pcIn + PC_W'(ofsFull);
  end

  always_comb begin
    stkEmpty = (fillCnt == '0);
    stkFull  = (fillCnt == CNT_W'(DEPTH));
    wrIdx    = IDX_W'(fillCnt);
    topIdx   = stkEmpty ? '0 : IDX_W'(fillCnt - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (strobe.push) begin
      fillCnt <= fillCnt + CNT_W'(1);
    end else if (strobe.pop) begin
      fillCnt <= fillCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (strobe.push && (wrIdx == IDX_W'(e))) begin
        valMem[e] <= opA;
        retMem[e] <= seqPc;
      end
    end
  end

  always_comb begin
    if (strobe.toCall)      nextPc = callTgt;
    else if (strobe.toRet)  nextPc = retMem[topIdx];
    else                    nextPc = seqPc;
  end

  always_comb begin
    resultC = strobe.mixStored ? (opA ^ valMem[topIdx]) : opA;
  end

endmodule

// File: rtl/callRetUnit.sv
module callRetUnit
  import callret_pkg::*;
#(
  parameter int  PROG_INSTR = 256,
  parameter int  DEPTH      = 8,
  localparam int PC_W       = $clog2(PROG_INSTR) + 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            instValid,
  input  logic [1:0]      opClass,
  input  logic [63:0]     opA,
  input  logic [63:0]     opB,
  input  logic [31:0]     imm32,
  input  logic [7:0]      imm8,
  input  logic [PC_W-1:0] pcIn,
  output logic [PC_W-1:0] nextPc,
  output logic [63:0]     resultC,
  output logic            resultWe,
  output logic            stackPush,
  output logic            stackPop
);

  crStrobe_t strobe;
  logic      cmpLe;
  logic      stkEmpty;
  logic      stkFull;

  callRetCtrl ctrl_i (
    .instValid (instValid),
    .opClass   (opClass),
    .cmpLe     (cmpLe),
    .stkEmpty  (stkEmpty),
    .stkFull   (stkFull),
    .strobe    (strobe)
  );

  callRetDatapath #(
    .DEPTH (DEPTH),
    .PC_W  (PC_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .imm32    (imm32),
    .imm8     (imm8),
    .pcIn     (pcIn),
    .cmpLe    (cmpLe),
    .stkEmpty (stkEmpty),
    .stkFull  (stkFull),
    .nextPc   (nextPc),
    .resultC  (resultC)
  );

  assign resultWe  = strobe.writeC;
  assign stackPush = strobe.push;
  assign stackPop  = strobe.pop;

endmodule

// File: rtl/callRetChk.sv
module callRetChk #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            instValid,
  input logic [1:0]      opClass,
  input logic [63:0]     opA,
  input logic [7:0]      imm8,
  input logic [PC_W-1:0] pcIn,
  input logic [PC_W-1:0] nextPc,
  input logic [63:0]     resultC,
  input logic            resultWe,
  input logic            stackPush,
  input logic            stackPop
);

  int unsigned chkDepth;
  logic [PC_W-1:0] expSeq;
  logic [PC_W-1:0] expCall;
  logic isCr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          chkDepth <= 0;
    else if (stackPush) chkDepth <= chkDepth + 1;
    else if (stackPop)  chkDepth <= chkDepth - 1;
  end

  always_comb begin
    expSeq  = pcIn + PC_W'(16);
    expCall = pcIn + PC_W'((int'(imm8[6:0]) + 1) * 16);
    isCr    = instValid && (opClass == 2'b01 || opClass == 2'b10);
  end

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rstN)
    (resultWe && !stackPop) |-> (resultC == opA));                          // R2
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rstN)
    (isCr && !stackPush && !stackPop) |-> (nextPc == expSeq));              // R2
  AST_CALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stackPush |-> (!resultWe && !stackPop));                                // R3
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    stackPush |-> (nextPc == expCall));                                     // R4
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stackPop |-> (chkDepth != 0));                                          // R5
  AST_POP_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    stackPop |-> resultWe);                                                 // R6
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    stackPush |-> (chkDepth < DEPTH));                                      // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !isCr |-> (!resultWe && !stackPush && !stackPop && nextPc == expSeq));  // R9

endmodule

bind callRetUnit callRetChk #(
  .DEPTH (DEPTH),
  .PC_W  (PC_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .instValid (instValid),
  .opClass   (opClass),
  .opA       (opA),
  .imm8      (imm8),
  .pcIn      (pcIn),
  .nextPc    (nextPc),
  .resultC   (resultC),
  .resultWe  (resultWe),
  .stackPush (stackPush),
  .stackPop  (stackPop)
);

// File: tb/callRetUnit_tb_top.sv
`timescale 1ns/1ps
module callRetUnit_tb_top;

  localparam int PROG_INSTR = 256;
  localparam int DEPTH      = 8;
  localparam int PC_W       = 12;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instValid = 1'b0;
  logic [1:0]      opClass = 2'b00;
  logic [63:0]     opA = '0;
  logic [63:0]     opB = '0;
  logic [31:0]     imm32 = '0;
  logic [7:0]      imm8 = '0;
  logic [PC_W-1:0] pcIn = '0;
  logic [PC_W-1:0] nextPc;
  logic [63:0]     resultC;
  logic            resultWe;
  logic            stackPush;
  logic            stackPop;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench stack model
  logic [63:0]     mVal [DEPTH];
  logic [PC_W-1:0] mRet [DEPTH];
  int              mSp = 0;

  always #2.5 clk = ~clk;

  callRetUnit #(.PROG_INSTR(PROG_INSTR), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .opClass(opClass),
    .opA(opA), .opB(opB), .imm32(imm32), .imm8(imm8), .pcIn(pcIn),
    .nextPc(nextPc), .resultC(resultC), .resultWe(resultWe),
    .stackPush(stackPush), .stackPop(stackPop)
  );

  function automatic bit condTrue(input logic [63:0] b, input logic [31:0] imm);
    return b <= {{32{imm[31]}}, imm};   // R1
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    instValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mSp = 0;                            // R10
  endtask

  task automatic step(input logic v, input logic [1:0] cls, input logic [63:0] a,
                      input logic [63:0] b, input logic [31:0] imm,
                      input logic [7:0] i8, input logic [PC_W-1:0] pc,
                      input string note);
    logic [PC_W-1:0] ePc;
    logic [63:0]     eC;
    logic            eWe, ePush, ePop;
    string           req;
    bit              cnd;
    @(negedge clk);
    instValid = v; opClass = cls; opA = a; opB = b; imm32 = imm; imm8 = i8; pcIn = pc;
    #1;
    cnd = condTrue(b, imm);
    ePc = pc + PC_W'(16); eC = a; eWe = 1'b0; ePush = 1'b0; ePop = 1'b0;
    if (!v || !(cls == 2'b01 || cls == 2'b10)) begin
      req = "R9";
    end else if (cls == 2'b01) begin
      if (cnd && mSp < DEPTH) begin
        req = "R3/R4";
        ePush = 1'b1;
        ePc = pc + PC_W'((int'(i8[6:0]) + 1) * 16);   // R4, R11 wrap
      end else begin
        req = cnd ? "R7" : "R2";
        eWe = 1'b1;
      end
    end else begin
      eWe = 1'b1;
      if (cnd && mSp > 0) begin
        req = "R6/R8";
        ePop = 1'b1;
        eC = a ^ mVal[mSp-1];
        ePc = mRet[mSp-1];
      end else begin
        req = cnd ? "R5" : "R2";
      end
    end
    checks++;
    if (nextPc !== ePc || resultC !== eC || resultWe !== eWe ||
        stackPush !== ePush || stackPop !== ePop) begin
      fails++;
      $display("FAIL %s (%s): pc=%h C=%h we=%b push=%b pop=%b expected pc=%h C=%h we=%b push=%b pop=%b",
               req, note, nextPc, resultC, resultWe, stackPush, stackPop,
               ePc, eC, eWe, ePush, ePop);
    end
    if (ePush) begin
      mVal[mSp] = a;
      mRet[mSp] = pc + PC_W'(16);       // R3
      mSp++;
    end else if (ePop) begin
      mSp--;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    doReset();
    // R10: empty after reset, so a satisfied return passes through (R5)
    step(1, 2'b10, 64'h1234, 64'd0, 32'd5, 8'd0, 12'h100, "R10 reset empty");
    // R1 boundary: B equal to immediate is taken
    step(1, 2'b01, 64'hAAAA_0000_5555_1111, 64'd77, 32'd77, 8'd2, 12'h040, "R1 equal");
    // R1: B one above is not taken
    step(1, 2'b01, 64'h5, 64'd78, 32'd77, 8'd2, 12'h200, "R1 above");
    // R1: negative immediate sign-extends to all ones
    step(1, 2'b01, 64'hDEAD_BEEF, 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 8'hFF, 12'h300, "R1 sext R4 imm8[7]");
    // R1: positive immediate does not reach a large B
    step(1, 2'b10, 64'h9, 64'h8000_0000_0000_0000, 32'h7FFF_FFFF, 8'd0, 12'h310, "R1 unsigned");
    // R9: ignored class and invalid call leave the stack alone
    step(1, 2'b11, 64'h1, 64'd0, 32'd9, 8'd0, 12'h400, "R9 class 3");
    step(1, 2'b00, 64'h2, 64'd0, 32'd9, 8'd0, 12'h410, "R9 class 0");
    step(0, 2'b01, 64'h3, 64'd0, 32'd9, 8'd0, 12'h420, "R9 not valid");
    // R11: sequential PC wraps, call target wraps
    step(1, 2'b01, 64'h4, 64'd9, 32'd1, 8'd0, 12'hFF0, "R11 seq wrap");
    step(1, 2'b01, 64'h77, 64'd0, 32'd1, 8'd3, 12'hFE0, "R11 call wrap");
    // R8/R6: unwind in LIFO order
    step(1, 2'b10, 64'hF0F0, 64'd0, 32'd0, 8'd0, 12'h500, "R8 pop 1");
    step(1, 2'b10, 64'h0F0F, 64'd0, 32'd0, 8'd0, 12'h510, "R8 pop 2");
    step(1, 2'b10, 64'h1, 64'd0, 32'd0, 8'd0, 12'h520, "R6 pop 3");
    step(1, 2'b10, 64'h2, 64'd0, 32'd0, 8'd0, 12'h530, "R5 empty again");
    // R7: fill to DEPTH, then one more call
    for (int k = 0; k < DEPTH + 2; k++)
      step(1, 2'b01, 64'(k * 3 + 1), 64'd0, 32'd0, 8'(k), 12'(k * 32), "R7 fill");
    for (int k = 0; k < DEPTH + 1; k++)
      step(1, 2'b10, 64'(k), 64'd0, 32'd0, 8'd0, 12'h800, "R8 drain");
    // R10: reset while entries exist
    step(1, 2'b01, 64'h55, 64'd0, 32'd0, 8'd1, 12'h0, "R10 prefill");
    doReset();
    step(1, 2'b10, 64'h66, 64'd0, 32'd0, 8'd0, 12'h10, "R10 cleared");
    // random mix
    for (int n = 0; n < 2000; n++) begin
      logic [63:0] rb;
      logic [31:0] ri;
      if ($urandom % 4 != 0) begin
        rb = 64'($urandom % 8);
        ri = 32'($urandom % 8);
      end else begin
        rb = {$urandom, $urandom};
        ri = $urandom;
      end
      step(($urandom % 10) != 0, 2'($urandom % 4), {$urandom, $urandom}, rb, ri,
           8'($urandom), 12'($urandom % 256) << 4, "random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule